// File: doc/BRIEF.md
# E1 Transmit Backplane Signaling Inserter

This block takes one E1 channel arriving on a 2.048 Mbit/s serial backplane and rebuilds its outgoing frame as a stream of parallel octets. Three serial inputs share the backplane timing: a frame pulse, a data line and a separate signaling line. The block runs on one fast system clock. It sees the backplane clock only as two single-cycle enables, one for the rising edge and one for the falling edge. Two configuration bits choose, each on its own, which edge samples the data and signaling lines and which edge samples the frame pulse.

Each timeslot is deserialised from both lines. The low nibble of every signaling octet holds that channel's ABCD bits, and the block keeps it in a 32-entry store. When channel-associated signaling is in force, timeslot 16 is rebuilt from that store over a 16-frame multiframe: frame 0 carries the multiframe alignment word, and every other frame carries two channels' signaling. Otherwise timeslot 16 is passed through as received. Each completed octet leaves the block as one strobe, together with its slot number, its frame-in-multiframe index and the octet value.

An alignment state machine has three states. In `ST_HUNT` the block ignores the lines and produces no output. A sampled frame pulse moves it to `ST_ARMED`. The next data-sampling edge moves it to `ST_RUN`, and that edge also takes bit 1 of TS0. In `ST_RUN` the bit, slot and frame counters run freely. Any later sampled frame pulse leaves the state at `ST_RUN` and realigns the counters at the following data edge.

Top module: `e1_tx_sig_insert`

## Requirements
- R1: After reset, and until a frame pulse has been sampled, `oct_valid` stays 0.
- R2: Data and signaling are sampled on the rising enable when `cfg_data_fall`=0 and on the falling enable when it is 1. `oct_valid` is high for exactly the one system cycle after the edge that samples bit 8 of a slot.
- R3: The frame pulse is sampled on the rising enable when `cfg_fp_fall`=0 and on the falling enable when it is 1. A sampled pulse makes the next data-sampling edge bit 1 of TS0. When the two edge bits differ, that edge lies in the same bit period as the pulse. When they are equal, it is one bit period later. The first octet reported is slot 0.
- R4: The first bit received in a slot appears at `oct_data[7]` and the eighth at `oct_data[0]`. Slots other than 16 are passed unchanged, and slot numbers rise by one from 0 to 31.
- R5: `oct_frame` is 0 in the first frame after alignment and rises by one, modulo 16, at each new frame, whether that frame is started by a frame pulse or by the slot counter wrapping.
- R6: Slot 16 is replaced with assembled signaling only when `cfg_ccs_en`=0 and `cfg_sig_src`=0.
- R7: When `cfg_ccs_en`=1 or `cfg_sig_src`=1, slot 16 is passed unchanged from the data line.
- R8: When it is replaced, slot 16 of frame 0 is 8'h0F: four zeros followed by four ones.
- R9: When it is replaced, slot 16 of frame k (1 to 15) is {ABCD of channel k, ABCD of channel k+16}. The signaling bits are taken from bit positions 5 to 8 of the signaling octet, with A (position 5) as the nibble MSB. Positions 1 to 4 are ignored.
- R10: The assembled slot 16 uses the newest captured nibbles. Channel k comes from the current frame and channel k+16 from the previous frame, so values change from one multiframe to the next.
- R11: A frame pulse that arrives mid-frame while running drops the partial octet and restarts counting at TS0, and the frame index advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_rise | input | 1 | One-cycle enable marking a rising backplane clock edge |
| bclk_fall | input | 1 | One-cycle enable marking a falling backplane clock edge |
| cfg_data_fall | input | 1 | Sampling edge for data and signaling: 0 rising, 1 falling |
| cfg_fp_fall | input | 1 | Sampling edge for the frame pulse: 0 rising, 1 falling |
| cfg_ccs_en | input | 1 | Common-channel signaling on (blocks slot 16 replacement) |
| cfg_sig_src | input | 1 | Signaling source select: 0 uses the signaling line |
| fp_in | input | 1 | Backplane frame pulse |
| data_in | input | 1 | Serial data line |
| sig_in | input | 1 | Serial signaling line |
| oct_valid | output | 1 | One-cycle strobe per completed octet |
| oct_slot | output | 5 | Timeslot number of the octet |
| oct_frame | output | 4 | Frame index within the multiframe |
| oct_data | output | 8 | Octet value, first received bit at bit 7 |

## Verification
The assertions assume that the rising and falling enables are single-cycle pulses that alternate, never fall in the same cycle, and are at least two system cycles apart. They also assume that the four configuration bits change only while reset is held. The stimulus produces the enables from a fixed four-cycle pattern, with the rising enable two cycles before the falling enable. It applies each configuration and then resets the block, so the enable spacing and the static configuration hold throughout. Serial bits are driven right after a data-sampling edge and held until the next one. This keeps every sampled value stable in both edge selections.

// File: rtl/e1_sig_pkg.sv
package e1_sig_pkg;

    // Alignment state of the backplane receiver.
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,   // no frame pulse seen since reset
        ST_ARMED = 2'd1,   // pulse seen, waiting for the first data edge
        ST_RUN   = 2'd2    // counters running
    } align_state_t;

endpackage

// File: rtl/e1_bp_timing.sv
module e1_bp_timing
    import e1_sig_pkg::*;
#(
    parameter int BITS_PER_SLOT = 8,
    parameter int SLOTS         = 32,
    parameter int MF_FRAMES     = 16,
    localparam int BW = $clog2(BITS_PER_SLOT),
    localparam int SW = $clog2(SLOTS),
    localparam int FW = $clog2(MF_FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk_rise,
    input  logic          bclk_fall,
    input  logic          cfg_data_fall,
    input  logic          cfg_fp_fall,
    input  logic          fp_in,
    output logic          samp_o,
    output logic          octet_done_o,
    output logic [SW-1:0] slot_o,
    output logic [FW-1:0] frame_o
);

    align_state_t  state_q, state_d;
    logic          data_en, fp_en, fp_hit;
    logic          pend_q;
    logic          active, armed, samp, start;
    logic [BW-1:0] bit_q, cur_bit;
    logic [SW-1:0] slot_q, cur_slot;
    logic [FW-1:0] frame_q;
    logic          last_bit, last_slot, frame_begin;

    // Edge selection: each config bit picks one of the two enables.
    always_comb begin
        data_en = cfg_data_fall ? bclk_fall : bclk_rise;
        fp_en   = cfg_fp_fall   ? bclk_fall : bclk_rise;
        fp_hit  = fp_en & fp_in;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Transitions: HUNT->ARMED on a sampled pulse, ARMED->RUN on the next data edge.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (fp_hit)  state_d = ST_ARMED;
            ST_ARMED: if (data_en) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_HUNT;
        endcase
    end

    // Per-state outputs.
    always_comb begin
        active = 1'b0;
        armed  = 1'b0;
        unique case (state_q)
            ST_HUNT:  active = 1'b0;
            ST_ARMED: begin active = 1'b1; armed = 1'b1; end
            ST_RUN:   active = 1'b1;
            default:  active = 1'b0;
        endcase
    end

    // A sampled pulse waits here until the next data edge consumes it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q & ~samp) | fp_hit;
    end

    always_comb begin
        samp        = data_en & active;
        start       = samp & pend_q;
        cur_bit     = start ? '0 : bit_q;
        cur_slot    = start ? '0 : slot_q;
        last_bit    = (cur_bit  == BW'(BITS_PER_SLOT - 1));
        last_slot   = (cur_slot == SW'(SLOTS - 1));
        frame_begin = samp & (start | ((cur_bit == '0) && (cur_slot == '0)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            slot_q <= '0;
        end else if (samp) begin
            bit_q  <= last_bit ? '0 : cur_bit + 1'b1;
            if (last_bit) slot_q <= last_slot ? '0 : cur_slot + 1'b1;
            else          slot_q <= cur_slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (frame_begin) begin
            if (armed)                                 frame_q <= '0;
            else if (frame_q == FW'(MF_FRAMES - 1))    frame_q <= '0;
            else                                       frame_q <= frame_q + 1'b1;
        end
    end

    assign samp_o       = samp;
    assign octet_done_o = samp & last_bit;
    assign slot_o       = cur_slot;
    assign frame_o      = frame_q;

endmodule

// File: rtl/e1_serial_deser.sv
module e1_serial_deser #(
    parameter int BITS_PER_SLOT = 8,
    parameter int NIB_W         = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic                     data_in,
    input  logic                     sig_in,
    output logic [BITS_PER_SLOT-1:0] data_oct,
    output logic [NIB_W-1:0]         sig_nib
);

    logic [BITS_PER_SLOT-2:0] dsh_q, ssh_q;
    logic [BITS_PER_SLOT-1:0] sig_oct;

    // Octet as it stands once the bit on the line is included; earliest bit lands at the MSB.
    always_comb begin
        data_oct = {dsh_q, data_in};
        sig_oct  = {ssh_q, sig_in};
        sig_nib  = sig_oct[NIB_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dsh_q <= '0;
            ssh_q <= '0;
        end else if (shift_en) begin
            dsh_q <= data_oct[BITS_PER_SLOT-2:0];
            ssh_q <= sig_oct[BITS_PER_SLOT-2:0];
        end
    end

endmodule

// File: rtl/e1_sig_store.sv
module e1_sig_store #(
    parameter int ENTRIES = 32,
    parameter int NIB_W   = 4,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [NIB_W-1:0] wr_nib,
    input  logic [IW-1:0]    rd_a_idx,
    input  logic [IW-1:0]    rd_b_idx,
    output logic [NIB_W-1:0] rd_a,
    output logic [NIB_W-1:0] rd_b
);

    logic [ENTRIES-1:0][NIB_W-1:0] mem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (wr_en && (wr_idx == IW'(e))) mem_q[e] <= wr_nib;
            end
        end
    end

    always_comb begin
        rd_a = mem_q[rd_a_idx];
        rd_b = mem_q[rd_b_idx];
    end

endmodule

// File: rtl/e1_tx_sig_insert.sv
module e1_tx_sig_insert
    import e1_sig_pkg::*;
#(
    parameter int              BITS_PER_SLOT = 8,
    parameter int              SLOTS         = 32,
    parameter int              MF_FRAMES     = 16,
    parameter int              SIG_SLOT      = 16,
    parameter int              NIB_W         = 4,
    parameter logic [7:0]      MFA_WORD      = 8'h0F,
    localparam int SW = $clog2(SLOTS),
    localparam int FW = $clog2(MF_FRAMES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bclk_rise,
    input  logic                     bclk_fall,
    input  logic                     cfg_data_fall,
    input  logic                     cfg_fp_fall,
    input  logic                     cfg_ccs_en,
    input  logic                     cfg_sig_src,
    input  logic                     fp_in,
    input  logic                     data_in,
    input  logic                     sig_in,
    output logic                     oct_valid,
    output logic [SW-1:0]            oct_slot,
    output logic [FW-1:0]            oct_frame,
    output logic [BITS_PER_SLOT-1:0] oct_data
);

    localparam int HALF = SLOTS / 2;

    logic                     samp, done;
    logic [SW-1:0]            slot;
    logic [FW-1:0]            frame;
    logic [BITS_PER_SLOT-1:0] data_oct;
    logic [NIB_W-1:0]         sig_nib, nib_lo_ch, nib_hi_ch;
    logic [SW-1:0]            rd_a_idx, rd_b_idx;
    logic                     cas_on;
    logic [BITS_PER_SLOT-1:0] ts16_word, out_word;

    e1_bp_timing #(
        .BITS_PER_SLOT(BITS_PER_SLOT),
        .SLOTS        (SLOTS),
        .MF_FRAMES    (MF_FRAMES)
    ) u_timing (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_rise    (bclk_rise),
        .bclk_fall    (bclk_fall),
        .cfg_data_fall(cfg_data_fall),
        .cfg_fp_fall  (cfg_fp_fall),
        .fp_in        (fp_in),
        .samp_o       (samp),
        .octet_done_o (done),
        .slot_o       (slot),
        .frame_o      (frame)
    );

    e1_serial_deser #(
        .BITS_PER_SLOT(BITS_PER_SLOT),
        .NIB_W        (NIB_W)
    ) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(samp),
        .data_in (data_in),
        .sig_in  (sig_in),
        .data_oct(data_oct),
        .sig_nib (sig_nib)
    );

    e1_sig_store #(
        .ENTRIES(SLOTS),
        .NIB_W  (NIB_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (done),
        .wr_idx  (slot),
        .wr_nib  (sig_nib),
        .rd_a_idx(rd_a_idx),
        .rd_b_idx(rd_b_idx),
        .rd_a    (nib_lo_ch),
        .rd_b    (nib_hi_ch)
    );

    // Slot 16 assembly: channel k and channel k+16 for frame k, alignment word in frame 0.
    always_comb begin
        rd_a_idx  = SW'(frame);
        rd_b_idx  = SW'(frame) + SW'(HALF);
        cas_on    = !cfg_ccs_en && !cfg_sig_src;
        ts16_word = (frame == '0) ? MFA_WORD : {nib_lo_ch, nib_hi_ch};
        out_word  = (cas_on && (slot == SW'(SIG_SLOT))) ? ts16_word : data_oct;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oct_valid <= 1'b0;
            oct_slot  <= '0;
            oct_frame <= '0;
            oct_data  <= '0;
        end else begin
            oct_valid <= done;
            if (done) begin
                oct_slot  <= slot;
                oct_frame <= frame;
                oct_data  <= out_word;
            end
        end
    end

endmodule

// File: rtl/e1_tx_sig_insert_chk.sv
module e1_tx_sig_insert_chk #(
    parameter int         SLOTS     = 32,
    parameter int         MF_FRAMES = 16,
    parameter int         SIG_SLOT  = 16,
    parameter logic [7:0] MFA_WORD  = 8'h0F,
    localparam int SW = $clog2(SLOTS),
    localparam int FW = $clog2(MF_FRAMES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bclk_rise,
    input logic          bclk_fall,
    input logic          cfg_fp_fall,
    input logic          cfg_ccs_en,
    input logic          cfg_sig_src,
    input logic          fp_in,
    input logic          oct_valid,
    input logic [SW-1:0] oct_slot,
    input logic [FW-1:0] oct_frame,
    input logic [7:0]    oct_data
);

    logic          fp_seen_q, have_q;
    logic [SW-1:0] last_slot_q, nxt_slot;
    logic [FW-1:0] last_frame_q, nxt_frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fp_seen_q    <= 1'b0;
            have_q       <= 1'b0;
            last_slot_q  <= '0;
            last_frame_q <= '0;
        end else begin
            if (fp_in && (cfg_fp_fall ? bclk_fall : bclk_rise)) fp_seen_q <= 1'b1;
            if (oct_valid) begin
                have_q       <= 1'b1;
                last_slot_q  <= oct_slot;
                last_frame_q <= oct_frame;
            end
        end
    end

    always_comb begin
        nxt_slot  = (last_slot_q  == SW'(SLOTS - 1))     ? '0 : last_slot_q  + 1'b1;
        nxt_frame = (last_frame_q == FW'(MF_FRAMES - 1)) ? '0 : last_frame_q + 1'b1;
    end

    assert_hunt_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_seen_q |-> !oct_valid);

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        oct_valid |=> !oct_valid);

    assert_first_octet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_valid && !have_q) |-> (oct_slot == '0 && oct_frame == '0));

    assert_slot_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_valid && have_q) |-> (oct_slot == nxt_slot || oct_slot == '0));

    assert_frame_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_valid && have_q) |->
            (oct_frame == last_frame_q || (oct_slot == '0 && oct_frame == nxt_frame)));

    assert_mfa_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_valid && !cfg_ccs_en && !cfg_sig_src &&
         oct_slot == SW'(SIG_SLOT) && oct_frame == '0) |-> (oct_data == MFA_WORD));

endmodule

bind e1_tx_sig_insert e1_tx_sig_insert_chk #(
    .SLOTS    (SLOTS),
    .MF_FRAMES(MF_FRAMES),
    .SIG_SLOT (SIG_SLOT),
    .MFA_WORD (MFA_WORD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_rise  (bclk_rise),
    .bclk_fall  (bclk_fall),
    .cfg_fp_fall(cfg_fp_fall),
    .cfg_ccs_en (cfg_ccs_en),
    .cfg_sig_src(cfg_sig_src),
    .fp_in      (fp_in),
    .oct_valid  (oct_valid),
    .oct_slot   (oct_slot),
    .oct_frame  (oct_frame),
    .oct_data   (oct_data)
);

// File: tb/tb_e1_tx_sig_insert.sv
module tb_e1_tx_sig_insert;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       bclk_rise = 1'b0, bclk_fall = 1'b0;
    logic       cfg_data_fall = 1'b0, cfg_fp_fall = 1'b0;
    logic       cfg_ccs_en = 1'b0, cfg_sig_src = 1'b0;
    logic       fp_in = 1'b0, data_in = 1'b0, sig_in = 1'b0;
    logic       oct_valid;
    logic [4:0] oct_slot;
    logic [3:0] oct_frame;
    logic [7:0] oct_data;

    e1_tx_sig_insert dut (
        .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .cfg_data_fall(cfg_data_fall), .cfg_fp_fall(cfg_fp_fall),
        .cfg_ccs_en(cfg_ccs_en), .cfg_sig_src(cfg_sig_src),
        .fp_in(fp_in), .data_in(data_in), .sig_in(sig_in),
        .oct_valid(oct_valid), .oct_slot(oct_slot), .oct_frame(oct_frame), .oct_data(oct_data)
    );

    // Backplane clock as enables: rise two cycles before fall, period four cycles.
    int ph = 0;
    always @(negedge clk) begin
        bclk_rise <= (ph == 0);
        bclk_fall <= (ph == 2);
        ph <= (ph + 1) % 4;
    end

    int n_cmp = 0, n_fail = 0;

    // Reference model state.
    bit         exp_v = 1'b0;
    int         exp_slot = 0, exp_frame = 0;
    logic [7:0] exp_data = 8'h00;
    string      exp_tag = "R4";
    bit         hunting = 1'b1;
    bit         realign = 1'b0;
    bit         cas = 1'b1;
    bit         first_frame = 1'b1;
    int         fidx = 0;
    int         frames_total = 0;
    bit [3:0]   sigm [32];

    task automatic report(string req, string what, int act, int expv);
        n_fail++;
        $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    endtask

    // Compared on every clock at the falling edge.
    always @(negedge clk) begin
        n_cmp++;
        if (!rst_n) begin
            if (oct_valid !== 1'b0) report("R1", "oct_valid in reset", int'(oct_valid), 0);
        end else begin
            if (oct_valid !== exp_v) begin
                report(hunting ? "R1" : "R2", "oct_valid", int'(oct_valid), int'(exp_v));
            end else if (exp_v) begin
                n_cmp += 2;
                if (oct_slot !== 5'(exp_slot))
                    report(realign ? "R11" : "R3", "oct_slot", int'(oct_slot), exp_slot);
                if (oct_frame !== 4'(exp_frame))
                    report(realign ? "R11" : "R5", "oct_frame", int'(oct_frame), exp_frame);
                if (oct_data !== exp_data)
                    report(exp_tag, $sformatf("oct_data slot %0d frame %0d", exp_slot, exp_frame),
                           int'(oct_data), int'(exp_data));
            end
            exp_v = 1'b0;
        end
    end

    task automatic wait_data_edge();
        do @(posedge clk); while (!(cfg_data_fall ? bclk_fall : bclk_rise));
    endtask

    task automatic send_bit(bit d, bit s, bit f, bit expect_it, int slot, int fr,
                            logic [7:0] val, string tag);
        @(negedge clk);
        data_in = d;
        sig_in  = s;
        fp_in   = f;
        wait_data_edge();
        if (expect_it) begin
            exp_v     = 1'b1;
            exp_slot  = slot;
            exp_frame = fr;
            exp_data  = val;
            exp_tag   = tag;
        end
    endtask

    task automatic send_idle(int n, bit fp_last);
        for (int i = 0; i < n; i++)
            send_bit(1'($urandom), 1'($urandom), fp_last && (i == n - 1), 1'b0, 0, 0, 8'h00, "R1");
    endtask

    // Sends the first nbits of a frame. Pulse placement follows R3.
    task automatic send_frame(int nbits, bit fp_here, bit fp_next);
        bit same_edge;
        same_edge = (cfg_data_fall == cfg_fp_fall);
        fidx = first_frame ? 0 : (fidx + 1) % 16;
        first_frame = 1'b0;
        hunting = 1'b0;
        for (int slot = 0; slot < 32; slot++) begin
            logic [7:0] dbyte, sbyte, word;
            string      tag;
            if (slot * 8 >= nbits) break;
            dbyte = 8'($urandom);
            sbyte = 8'($urandom);
            if (slot != 16) begin
                word = dbyte; tag = "R4";
            end else if (!cas) begin
                word = dbyte; tag = "R7";
            end else if (fidx == 0) begin
                word = 8'h0F; tag = "R6 R8";
            end else begin
                word = {sigm[fidx], sigm[fidx + 16]};
                tag  = (frames_total < 16) ? "R6 R9" : "R6 R10";
            end
            for (int b = 0; b < 8; b++) begin
                int  gi;
                bit  f;
                gi = slot * 8 + b;
                if (gi >= nbits) break;
                f = same_edge ? (fp_next && gi == nbits - 1) : (fp_here && gi == 0);
                send_bit(dbyte[7 - b], sbyte[7 - b], f, b == 7, slot, fidx, word, tag);
            end
            if (slot * 8 + 8 <= nbits) sigm[slot] = sbyte[3:0];
        end
        frames_total++;
    endtask

    task automatic do_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        fp_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_scen(bit de, bit fe, bit ccs, bit src, int nframes, bit fp_every, bit partial);
        bit same_edge;
        cfg_data_fall = de;
        cfg_fp_fall   = fe;
        cfg_ccs_en    = ccs;
        cfg_sig_src   = src;
        do_reset();
        cas = !ccs && !src;
        for (int i = 0; i < 32; i++) sigm[i] = 4'h0;
        first_frame  = 1'b1;
        hunting      = 1'b1;
        realign      = 1'b0;
        frames_total = 0;
        same_edge    = (de == fe);
        // R1: random data with no pulse yields nothing.
        send_idle(6, same_edge);
        for (int i = 0; i < nframes; i++)
            send_frame(256, fp_every || (i == 0), fp_every);
        if (partial) begin
            send_frame(45, 1'b1, 1'b1);
            realign = 1'b1;            // R11: next frame restarts at TS0
            send_frame(256, 1'b1, 1'b1);
            realign = 1'b0;
            send_frame(256, 1'b1, 1'b1);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        // R2/R3: data rising, pulse falling (differing edges), CAS on, pulse every frame.
        run_scen(1'b0, 1'b1, 1'b0, 1'b0, 18, 1'b1, 1'b1);
        // R5: data falling, pulse rising, pulse only once, counters free-run.
        run_scen(1'b1, 1'b0, 1'b0, 1'b0, 17, 1'b0, 1'b0);
        // R7: equal edges, common-channel signaling on, with realignment.
        run_scen(1'b0, 1'b0, 1'b1, 1'b0, 3, 1'b1, 1'b1);
        // R6/R10: equal falling edges, CAS on across two multiframes.
        run_scen(1'b1, 1'b1, 1'b0, 1'b0, 17, 1'b1, 1'b0);
        // R7: source select set blocks replacement.
        run_scen(1'b1, 1'b0, 1'b0, 1'b1, 2, 1'b1, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule